// File: doc/BRIEF.md
# Bit-Serial Truncating Coefficient Multiplier

This block multiplies a stream of 24-bit two's complement data words by a 14-bit signed coefficient. The data arrive one bit per clock, least significant bit first. A framing strobe is high in the clock that carries bit 0 of each word. The coefficient is a signed fraction with one sign bit and thirteen fraction bits, so it spans -1.0 up to just below +1.0. The product therefore keeps the scale of the data word. The block drops the thirteen lowest bits of the full 38-bit product and sends out the next 24 bits serially, LSB first. Each result word carries its own framing strobe and starts exactly one word time after the data word that produced it.

The coefficient also arrives serially, on its own pin, in the first fourteen bit positions of a word. It is captured into a holding register at the following word boundary and applies to the data word that starts at that boundary. A host can therefore change the coefficient every word, one word ahead of the data it scales. Inside the block, each data bit adds the shifted coefficient to a running sum. The data sign bit subtracts it instead. The finished sum is handed to an output shift register at the next word boundary.

Top module: `serial_coef_mult`

## Requirements
- R1: After reset, `lsb_out` and `dout` are 0. The result word sent at the first `lsb_in` after reset is all zeros, and the coefficient used for the first data word is 0.
- R2: When `lsb_in` is sampled high at a clock edge, `lsb_out` is high for the following clock period only. The result for the data word whose bit 0 was sampled at edge E has its bit k on `dout` during the period after edge E+24+k, for k = 0 to 23.
- R3: The result equals floor(d × c / 2^13) modulo 2^24. Here d is the 24-bit data word read as signed, and c is the 14-bit coefficient read as signed.
- R4: Coefficient bit j (j = 0 to 13, LSB first) is taken from `coef_in` in the clock of bit position j of a word, where position 0 is the clock with `lsb_in` high. That coefficient multiplies the data word that starts at the next `lsb_in`.
- R5: `coef_in` is ignored in bit positions 14 to 23 of a word.
- R6: Low product bits are truncated toward negative infinity, not rounded. A product of -1 by the smallest positive coefficient (code 0x0001) gives 0xFFFFFF, and -1 by code 0x3FFF gives 0.
- R7: Negative data and negative coefficients are both handled as signed values. Coefficient code 0x2000 means -1.0 and 0x3000 means -0.5.
- R8: The single out-of-range case, data 0x800000 times coefficient 0x2000, wraps to 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one data bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| lsb_in | input | 1 | High in the clock carrying bit 0 of an input word |
| din | input | 1 | Serial data operand, LSB first |
| coef_in | input | 1 | Serial coefficient, LSB first, bit positions 0 to 13 |
| lsb_out | output | 1 | High in the clock carrying bit 0 of a result word |
| dout | output | 1 | Serial truncated product, LSB first |

## Verification
A result is due 24 clocks after its data word begins. The coefficient it uses was shifted in during the word before that one. The driver drives inputs on falling edges and pushes each word's expected result into a queue. The expected value is computed from the coefficient of the previous word. The monitor waits for `lsb_out` on a falling edge, gathers the next 24 `dout` bits from the falling edges that follow, and compares them with the head of the queue. It also checks that successive `lsb_out` pulses are exactly 24 clocks apart, so a result that arrives a clock early or late shows up as a spacing error or as shifted bits.

// File: rtl/serial_coef_mult.sv
module serial_coef_mult #(
  parameter int DW = 24,
  parameter int CW = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic lsb_in,
  input  logic din,
  input  logic coef_in,
  output logic lsb_out,
  output logic dout
);
  localparam int FRAC = CW - 1;
  localparam int PW   = DW + CW;
  localparam int CNTW = $clog2(DW + 1);

  logic [CNTW-1:0] cnt, idx;
  logic [CW-1:0]   coef_sr, coef_q, coef_eff;
  logic [PW-1:0]   acc, acc_base, coef_ext, term, acc_next;
  logic [DW-1:0]   out_sr;
  logic            take, neg;

  assign idx      = lsb_in ? '0 : cnt;
  assign coef_eff = lsb_in ? coef_sr : coef_q;
  assign coef_ext = {{DW{coef_eff[CW-1]}}, coef_eff};
  assign term     = coef_ext << idx;
  assign take     = din && (idx < CNTW'(DW));
  assign neg      = (idx == CNTW'(DW - 1));
  assign acc_base = lsb_in ? '0 : acc;
  assign acc_next = !take ? acc_base : (neg ? acc_base - term : acc_base + term);
  assign dout     = out_sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= CNTW'(DW);
      coef_sr <= '0;
      coef_q  <= '0;
      acc     <= '0;
      out_sr  <= '0;
      lsb_out <= 1'b0;
    end else begin
      lsb_out <= lsb_in;
      acc     <= acc_next;
      if (lsb_in)                 cnt <= CNTW'(1);
      else if (cnt != CNTW'(DW))  cnt <= cnt + CNTW'(1);
      if (idx < CNTW'(CW))        coef_sr <= {coef_in, coef_sr[CW-1:1]};
      if (lsb_in) begin
        coef_q <= coef_sr;
        out_sr <= acc[FRAC+DW-1:FRAC];
      end else begin
        out_sr <= {1'b0, out_sr[DW-1:1]};
      end
    end
  end

  assert_word_start_R3: assert property (@(posedge clk) disable iff (rst)
    (lsb_in && !din) |=> (acc == '0));

  assert_coef_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (!lsb_in && cnt >= CNTW'(CW)) |=> $stable(coef_sr));

  assert_shift_out_R2: assert property (@(posedge clk) disable iff (rst)
    !lsb_in |=> (!lsb_out && out_sr[DW-2:0] == $past(out_sr[DW-1:1])));

  assert_zero_coef_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!lsb_in && coef_q == '0) |=> $stable(acc));

  assert_result_sign_R7: assert property (@(posedge clk) disable iff (rst)
    (lsb_in && acc == '0) |=> (out_sr == '0));
endmodule

// File: tb/serial_coef_mult_bench.sv
module serial_coef_mult_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lsb_in = 1'b0, din = 1'b0, coef_in = 1'b0;
  logic lsb_out, dout;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [CW-1:0] cur_coef = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_coef_mult #(.DW(DW), .CW(CW)) u_serial_coef_mult (
    .clk(clk), .rst(rst), .lsb_in(lsb_in), .din(din), .coef_in(coef_in),
    .lsb_out(lsb_out), .dout(dout));

  function automatic logic [DW-1:0] model(logic [DW-1:0] d, logic [CW-1:0] c);
    longint dd, cc, p;
    dd = longint'($signed(d));
    cc = longint'($signed(c));
    p  = (dd * cc) >>> (CW - 1);
    return p[DW-1:0];
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(logic [DW-1:0] d, logic [CW-1:0] cn, bit junk, string req);
    exp_q.push_back(model(d, cur_coef));
    tag_q.push_back(req);
    cur_coef = cn;
    for (int b = 0; b < DW; b++) begin
      @(negedge clk);
      lsb_in  = (b == 0);
      din     = d[b];
      coef_in = (b < CW) ? cn[b] : (junk ? ~b[0] : 1'b0);
    end
  endtask

  initial begin : monitor
    int cyc = 0, last = 0, pos = -1;
    bit seen = 0;
    logic [DW-1:0] word = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (lsb_out) begin
          if (seen) check((cyc - last) == DW, "R2 lsb_out spacing", DW'(cyc - last), DW'(DW));
          seen = 1; last = cyc; pos = 0;
        end
        if (pos >= 0) begin
          word[pos] = dout;
          pos++;
          if (pos == DW) begin
            pos = -1;
            if (exp_q.size() == 0) check(0, "R2 unexpected result", word, '0);
            else begin
              logic [DW-1:0] e;
              string t;
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              check(word == e, t, word, e);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", '0, '0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [DW-1:0] lf;
    exp_q.push_back('0);
    tag_q.push_back("R1 first result after reset");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(lsb_out == 1'b0 && dout == 1'b0, "R1 reset outputs", {22'd0, lsb_out, dout}, '0);
    send(24'h000123, 14'h1000, 0, "R1 R4 first coefficient zero");
    send(24'h100000, 14'h0800, 0, "R3 R4 positive by 0.5");
    send(24'hF00000, 14'h3000, 0, "R7 negative data");
    send(24'h200000, 14'h3FFF, 0, "R7 negative coefficient -0.5");
    send(24'hFFFFFF, 14'h0001, 0, "R6 -1 times -lsb");
    send(24'hFFFFFF, 14'h2000, 0, "R6 -1 times +lsb floors");
    send(24'h800000, 14'h2000, 0, "R8 overflow wraps");
    send(24'h800000, 14'h1FFF, 1, "R8 overflow wraps again");
    send(24'h555555, 14'h0ABC, 1, "R5 junk after coefficient bits");
    send(24'h7FFFFF, 14'h0000, 1, "R5 R3 junk ignored");
    send(24'h123456, 14'h2A5B, 0, "R3 zero coefficient");
    lf = 24'hACE135;
    for (int i = 0; i < 8; i++) begin
      lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
      send(lf, lf[CW+3:4], i[0], "R3 R7 mixed pattern");
    end
    send(24'h0, 14'h0, 0, "flush");
    @(negedge clk);
    lsb_in = 1'b0; din = 1'b0; coef_in = 1'b0;
    repeat (DW + 4) @(negedge clk);
    check(exp_q.size() == 1, "R2 all results delivered", DW'(exp_q.size()), DW'(1));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule